// File: doc/BRIEF.md
# Processor Status Register with Flag Generation

This block holds the 8-bit status word of a small 8-bit processor and produces its arithmetic flags. Each cycle it may receive one ALU operation (operation code and two operands). From these it derives the zero, nibble-carry and carry flags itself, and for each operation kind it decides which of those flags change. The same cycle may carry a write of the whole status word when an instruction names the register as its destination. Flag updates from the operation take priority over that write on the three flag bits. The wake-up-cause and page-select bits are plain read/write storage.

Two bits report the power and watchdog state. They are read-only and follow four events: power-up (reset), a watchdog-clear command, a sleep command and a watchdog expiry. The word is registered: every update is visible on `status_q` one clock after the cycle that caused it.

Top module: `cpu_flag_reg`

## Requirements
- R1: During and after reset, `status_q` reads 8'h18: TO (bit 4) and PD (bit 3) are 1, and bits 7, 6, 5 and the flags Z (bit 2), DC (bit 1) and C (bit 0) are 0.
- R2: Bit 6 always reads 0. A write of 1 to it has no effect.
- R3: Add (`op_sel` 0) computes a+b. C is set to the carry out of bit 7, DC to the carry out of bit 3, and Z to 1 exactly when the 8-bit sum is zero.
- R4: Subtract (`op_sel` 1) computes a-b. C is 1 when a >= b (no borrow), DC is 1 when a[3:0] >= b[3:0], and Z is 1 exactly when the 8-bit difference is zero.
- R5: Rotate left (`op_sel` 2) loads C with a[7]. Rotate right (`op_sel` 3) loads C with a[0]. Z and DC keep their values.
- R6: AND, OR, XOR and pass-through (`op_sel` 4, 5, 6, 7) set Z to 1 exactly when the result is zero. DC and C keep their values.
- R7: A write (`wr_en`) with no operation loads bits 7, 5, 2, 1 and 0 from `wr_data`.
- R8: When `wr_en` and `op_valid` are both high, bits 7 and 5 take `wr_data`. All of bits 2..0 ignore `wr_data`: each flag takes the operation's value or keeps its old value. For example, a pass-through of zero while writing 0 clears bits 7 and 5, sets Z, and leaves DC and C unchanged.
- R9: Writes never change TO or PD.
- R10: `wdt_expire` clears TO, and it wins over the other events. A sleep command sets TO and clears PD. A watchdog-clear command sets TO and PD. When sleep and watchdog-clear arrive in the same cycle, sleep wins for PD.
- R11: With no operation, no write and no event, the whole word holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| op_valid | input | 1 | An ALU operation executes this cycle |
| op_sel | input | 3 | Operation code: 0 add, 1 sub, 2 rotl, 3 rotr, 4 and, 5 or, 6 xor, 7 pass |
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second operand |
| wr_en | input | 1 | Instruction writes the status register |
| wr_data | input | 8 | Write data |
| clrwdt_cmd | input | 1 | Watchdog-clear command |
| sleep_cmd | input | 1 | Sleep command |
| wdt_expire | input | 1 | Watchdog timeout event |
| status_q | output | 8 | Registered status word |

## Verification
All state in this block is visible directly at `status_q`. A wrong flag, a write mask that merges the wrong bits, or a wrong priority between events therefore shows up one clock after the cycle that caused it. The reference model recomputes the expected word every clock, so a wrong bit is reported in the first cycle it appears. The error does not have to wait for a later operation to expose it. Directed cases cover the carry boundaries at bit 3 and bit 7, equal subtract operands, the clear-with-write case, and events that arrive in the same cycle. A long mixed random run then drives combinations of operations, writes and events.

// File: rtl/flagreg_pkg.sv
package flagreg_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_ROTL = 3'd2,
      OP_ROTR = 3'd3,
      OP_AND  = 3'd4,
      OP_IOR  = 3'd5,
      OP_XOR  = 3'd6,
      OP_PASS = 3'd7
   } alu_op_e;

   // status word bit positions (software-visible layout)
   localparam int ST_C    = 0;
   localparam int ST_DC   = 1;
   localparam int ST_Z    = 2;
   localparam int ST_PD   = 3;
   localparam int ST_TO   = 4;
   localparam int ST_PAGE = 5;
   localparam int ST_RSV  = 6;
   localparam int ST_WAKE = 7;
   localparam int ST_W    = 8;
   localparam int FLAG_N  = 3;

   typedef struct packed {
      logic z;
      logic dc;
      logic c;
   } flags_t;

endpackage

// File: rtl/flag_logic.sv
module flag_logic
   import flagreg_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              op_valid,
   input  logic [2:0]        op_sel,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic [FLAG_N-1:0] flag_val,
   output logic [FLAG_N-1:0] flag_upd
);

   localparam int HALF = DATA_W / 2;

   logic [DATA_W:0]   sum_w;
   logic [DATA_W:0]   dif_w;
   logic [HALF:0]     hsum_w;
   logic [HALF:0]     hdif_w;
   logic [DATA_W-1:0] logic_res;
   flags_t            val_s;
   flags_t            upd_s;

   assign sum_w  = {1'b0, opnd_a} + {1'b0, opnd_b};
   assign dif_w  = {1'b0, opnd_a} - {1'b0, opnd_b};
   assign hsum_w = {1'b0, opnd_a[HALF-1:0]} + {1'b0, opnd_b[HALF-1:0]};
   assign hdif_w = {1'b0, opnd_a[HALF-1:0]} - {1'b0, opnd_b[HALF-1:0]};

   always_comb begin
      unique case (alu_op_e'(op_sel))
         OP_AND:  logic_res = opnd_a & opnd_b;
         OP_IOR:  logic_res = opnd_a | opnd_b;
         OP_XOR:  logic_res = opnd_a ^ opnd_b;
         default: logic_res = opnd_a;
      endcase
   end

   always_comb begin
      val_s = '0;
      upd_s = '0;
      unique case (alu_op_e'(op_sel))
         OP_ADD: begin
            val_s = '{z: (sum_w[DATA_W-1:0] == '0), dc: hsum_w[HALF], c: sum_w[DATA_W]};
            upd_s = '{z: 1'b1, dc: 1'b1, c: 1'b1};
         end
         OP_SUB: begin
            val_s = '{z: (dif_w[DATA_W-1:0] == '0), dc: ~hdif_w[HALF], c: ~dif_w[DATA_W]};
            upd_s = '{z: 1'b1, dc: 1'b1, c: 1'b1};
         end
         OP_ROTL: begin
            val_s.c = opnd_a[DATA_W-1];
            upd_s.c = 1'b1;
         end
         OP_ROTR: begin
            val_s.c = opnd_a[0];
            upd_s.c = 1'b1;
         end
         default: begin
            val_s.z = (logic_res == '0);
            upd_s.z = 1'b1;
         end
      endcase
      if (!op_valid) upd_s = '0;
   end

   assign flag_val = val_s;
   assign flag_upd = upd_s;

endmodule

// File: rtl/wdt_status.sv
module wdt_status (
   input  logic clk,
   input  logic rst_n,
   input  logic clrwdt_cmd,
   input  logic sleep_cmd,
   input  logic wdt_expire,
   output logic to_q,
   output logic pd_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         to_q <= 1'b1;
         pd_q <= 1'b1;
      end else begin
         if (wdt_expire)                   to_q <= 1'b0;
         else if (clrwdt_cmd || sleep_cmd) to_q <= 1'b1;

         if (sleep_cmd)       pd_q <= 1'b0;
         else if (clrwdt_cmd) pd_q <= 1'b1;
      end
   end

endmodule

// File: rtl/cpu_flag_reg.sv
module cpu_flag_reg
   import flagreg_pkg::*;
#(
   parameter int         DATA_W   = 8,
   parameter logic [2:0] FLAG_RST = 3'b000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_sel,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   input  logic              clrwdt_cmd,
   input  logic              sleep_cmd,
   input  logic              wdt_expire,
   output logic [7:0]        status_q
);

   generate
      if ((DATA_W < 4) || (DATA_W % 2 != 0)) begin : g_bad_width
         $error("cpu_flag_reg: DATA_W must be even and at least 4");
      end
   endgenerate

   logic [FLAG_N-1:0] flag_val;
   logic [FLAG_N-1:0] flag_upd;
   logic [FLAG_N-1:0] flag_q;
   logic              any_upd;
   logic              to_q;
   logic              pd_q;
   logic              wake_q;
   logic              page_q;
   logic              wr_unused;

   assign wr_unused = ^{wr_data[ST_RSV], wr_data[ST_TO], wr_data[ST_PD]};

   flag_logic #(.DATA_W(DATA_W)) flags_i (
      .op_valid (op_valid),
      .op_sel   (op_sel),
      .opnd_a   (opnd_a),
      .opnd_b   (opnd_b),
      .flag_val (flag_val),
      .flag_upd (flag_upd)
   );

   wdt_status wdt_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .clrwdt_cmd (clrwdt_cmd),
      .sleep_cmd  (sleep_cmd),
      .wdt_expire (wdt_expire),
      .to_q       (to_q),
      .pd_q       (pd_q)
   );

   // any flag touched by the operation locks the whole flag field against the write
   assign any_upd = |flag_upd;

   generate
      for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            flag_q[i] <= FLAG_RST[i];
            else if (flag_upd[i])  flag_q[i] <= flag_val[i];
            else if (wr_en && !any_upd) flag_q[i] <= wr_data[ST_C + i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_q <= 1'b0;
         page_q <= 1'b0;
      end else if (wr_en) begin
         wake_q <= wr_data[ST_WAKE];
         page_q <= wr_data[ST_PAGE];
      end
   end

   always_comb begin
      status_q                       = '0;
      status_q[ST_WAKE]              = wake_q;
      status_q[ST_PAGE]              = page_q;
      status_q[ST_TO]                = to_q;
      status_q[ST_PD]                = pd_q;
      status_q[ST_Z:ST_C]            = flag_q;
   end

endmodule

// File: rtl/cpu_flag_reg_chk.sv
module cpu_flag_reg_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [2:0]        op_sel,
   input logic [DATA_W-1:0] opnd_a,
   input logic [DATA_W-1:0] opnd_b,
   input logic              wr_en,
   input logic [7:0]        wr_data,
   input logic              clrwdt_cmd,
   input logic              sleep_cmd,
   input logic              wdt_expire,
   input logic [7:0]        status_q
);

   logic no_evt;
   assign no_evt = !clrwdt_cmd && !sleep_cmd && !wdt_expire;

   // R9: TO/PD move only on events
   a_r9_to_pd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      no_evt |=> $stable(status_q[4:3]));

   // R10: expiry clears TO
   a_r10_expire_to: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_expire |=> !status_q[4]);

   // R10: sleep clears PD
   a_r10_sleep_pd: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_cmd |=> !status_q[3]);

   // R10: lone watchdog-clear sets both
   a_r10_clr_both: assert property (@(posedge clk) disable iff (!rst_n)
      (clrwdt_cmd && !sleep_cmd && !wdt_expire) |=> (status_q[4:3] == 2'b11));

   // R5: rotates keep Z and DC
   a_r5_rot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_sel == 3'd2 || op_sel == 3'd3)) |=> $stable(status_q[2:1]));

   // R6: logic ops keep DC and C
   a_r6_logic_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel[2]) |=> $stable(status_q[1:0]));

   // R3: add wrapping to zero sets Z
   a_r3_add_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == 3'd0 && (opnd_a + opnd_b) == '0) |=> status_q[2]);

   // R11: idle cycles hold the word
   a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid && !wr_en && no_evt) |=> $stable(status_q));

   // R7: lone write loads the upper storage bits
   a_r7_upper_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (status_q[7] == $past(wr_data[7]) && status_q[5] == $past(wr_data[5])));

endmodule

bind cpu_flag_reg cpu_flag_reg_chk #(.DATA_W(DATA_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_valid   (op_valid),
   .op_sel     (op_sel),
   .opnd_a     (opnd_a),
   .opnd_b     (opnd_b),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .clrwdt_cmd (clrwdt_cmd),
   .sleep_cmd  (sleep_cmd),
   .wdt_expire (wdt_expire),
   .status_q   (status_q)
);

// File: tb/cpu_flag_reg_tb_top.sv
`timescale 1ns/100ps
module cpu_flag_reg_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [2:0] op_sel = '0;
   logic [7:0] opnd_a = '0;
   logic [7:0] opnd_b = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       clrwdt_cmd = 1'b0;
   logic       sleep_cmd = 1'b0;
   logic       wdt_expire = 1'b0;
   logic [7:0] status_q;

   int n_run  = 0;
   int n_fail = 0;
   int exp_st = 8'h18;

   always #2.5 clk = ~clk;

   cpu_flag_reg dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .wr_en(wr_en), .wr_data(wr_data),
      .clrwdt_cmd(clrwdt_cmd), .sleep_cmd(sleep_cmd), .wdt_expire(wdt_expire),
      .status_q(status_q)
   );

   function automatic int bitv(int v, int p);
      return (v >> p) & 1;
   endfunction

   // behavioural next-state reference
   function automatic int model_next(int cur);
      int z, dc, c, to, pd, wk, pg, a, b, r;
      bit aff;
      z = bitv(cur, 2); dc = bitv(cur, 1); c = bitv(cur, 0);
      to = bitv(cur, 4); pd = bitv(cur, 3); wk = bitv(cur, 7); pg = bitv(cur, 5);
      a = opnd_a; b = opnd_b; aff = 0;
      if (op_valid) begin
         aff = 1;
         case (op_sel)
            0: begin r = a + b; c = (r > 255); dc = ((a % 16) + (b % 16) > 15); z = ((r % 256) == 0); end
            1: begin c = (a >= b); dc = ((a % 16) >= (b % 16)); z = (a == b); end
            2: c = a / 128;
            3: c = a % 2;
            4: z = ((a & b) == 0);
            5: z = ((a | b) == 0);
            6: z = ((a ^ b) == 0);
            default: z = (a == 0);
         endcase
      end
      if (wr_en) begin
         wk = bitv(wr_data, 7); pg = bitv(wr_data, 5);
         if (!aff) begin z = bitv(wr_data, 2); dc = bitv(wr_data, 1); c = bitv(wr_data, 0); end
      end
      if (wdt_expire) to = 0;
      else if (clrwdt_cmd || sleep_cmd) to = 1;
      if (sleep_cmd) pd = 0;
      else if (clrwdt_cmd) pd = 1;
      return wk*128 + pg*32 + to*16 + pd*8 + z*4 + dc*2 + c;
   endfunction

   task automatic check(string tag);
      n_run++;
      if (status_q !== exp_st[7:0]) begin
         n_fail++;
         $display("FAIL %s: status_q actual %02h expected %02h", tag, status_q, exp_st[7:0]);
      end
   endtask

   task automatic step(input bit v, input int op, input int a, input int b,
                       input bit w, input int wd, input bit cl, input bit sl,
                       input bit ex, input string tag);
      op_valid = v; op_sel = op[2:0]; opnd_a = a[7:0]; opnd_b = b[7:0];
      wr_en = w; wr_data = wd[7:0]; clrwdt_cmd = cl; sleep_cmd = sl; wdt_expire = ex;
      exp_st = model_next(exp_st);
      @(posedge clk); #1;
      check(tag);
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL R11: watchdog expired actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      exp_st = 8'h18;
      check("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset");

      // R7 / R2 / R9: lone writes
      step(0,0,0,0, 1,8'hFF, 0,0,0, "R7 write all ones, R2 bit6, R9 TO/PD");
      step(0,0,0,0, 1,8'h00, 0,0,0, "R9 write zero keeps TO/PD");
      step(0,0,0,0, 0,0,     0,0,0, "R11 idle hold");

      // R3 add boundaries
      step(1,0,8'h0F,8'h01, 0,0, 0,0,0, "R3 nibble carry");
      step(1,0,8'hFF,8'h01, 0,0, 0,0,0, "R3 full carry to zero");
      step(1,0,8'h80,8'h80, 0,0, 0,0,0, "R3 carry no nibble carry");
      step(1,0,8'h12,8'h34, 0,0, 0,0,0, "R3 no carry");

      // R4 subtract
      step(1,1,5,3,         0,0, 0,0,0, "R4 no borrow");
      step(1,1,3,5,         0,0, 0,0,0, "R4 borrow");
      step(1,1,8'h10,8'h01, 0,0, 0,0,0, "R4 nibble borrow only");
      step(1,1,7,7,         0,0, 0,0,0, "R4 equal operands");

      // R5 rotates keep Z/DC
      step(1,2,8'h80,0, 0,0, 0,0,0, "R5 rotl msb");
      step(1,3,8'h02,0, 0,0, 0,0,0, "R5 rotr lsb 0");
      step(1,3,8'h01,0, 0,0, 0,0,0, "R5 rotr lsb 1");

      // R6 logic keep DC/C
      step(1,4,8'hF0,8'h0F, 0,0, 0,0,0, "R6 and zero");
      step(1,5,8'h00,8'h01, 0,0, 0,0,0, "R6 or nonzero");
      step(1,6,8'h5A,8'h5A, 0,0, 0,0,0, "R6 xor zero");

      // R8 write blocked on flags
      step(0,0,0,0, 1,8'hA3, 0,0,0, "R7 preset flags");
      step(1,7,0,0, 1,8'h00, 0,0,0, "R8 clear with zero pass");
      step(1,0,8'h01,8'h01, 1,8'hFF, 0,0,0, "R8 add while writing");
      step(1,2,8'h00,0, 1,8'h07, 0,0,0, "R8 rotate locks Z/DC");

      // R10 events and priorities
      step(0,0,0,0, 0,0, 0,1,0, "R10 sleep");
      step(0,0,0,0, 0,0, 0,0,1, "R10 expire");
      step(0,0,0,0, 0,0, 1,0,0, "R10 clear");
      step(0,0,0,0, 0,0, 1,1,0, "R10 sleep beats clear");
      step(0,0,0,0, 0,0, 1,0,1, "R10 expire beats clear");
      step(0,0,0,0, 0,0, 0,1,1, "R10 expire beats sleep");
      step(0,0,0,0, 0,0, 0,0,0, "R11 idle after events");

      // mixed random traffic
      for (int i = 0; i < 400; i++) begin
         step(($urandom % 2) == 1, $urandom % 8, $urandom % 256, $urandom % 256,
              ($urandom % 3) == 0, $urandom % 256,
              ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
              "R8 mixed random");
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule